// File: doc/BRIEF.md
# Mailbox Message Channel Controller

This block drives the message mailboxes kept in a byte-wide RAM shared between a host and an I/O coprocessor. The RAM holds two mailbox areas, one for each direction. Each area has a maximum-channel byte, one state byte per channel and one 32-byte message slot per channel. A channel's state byte runs a fixed four-step handshake. The codes are 0 (idle), 1 (new message posted), 2 (received, being processed) and 3 (processing complete).

Two engines share one RAM port through a round-robin arbiter.

**Send engine.** It acts for the host in the send area.
- It accepts one message at a time and waits until the target channel is idle.
- It copies the 32 bytes into the channel's slot and posts state 1.
- It polls until the other side writes 3. It then reads the reply back from the same slot, writes state 0 and pulses `snd_done`.

**Receive engine.** It acts for the coprocessor in the receive area.
- After reset it writes the maximum-channel bytes of both areas and the alive byte.
- It then scans the receive channels in turn. When it finds a channel in state 1, it marks it 2 and reads the message out.
- It offers the message on `rcv_*` and waits for `rcv_ack`. It then writes the supplied reply into the slot and marks the channel 3.

Send engine states and transitions:
- IDLE goes to CHK_RD on a valid request.
- CHK_RD and CHK_WT poll the state byte. They loop while the channel is busy and go to MSG_WR once it is idle.
- MSG_WR writes the 32 message bytes, then moves to NEW_WR.
- NEW_WR posts state 1, then moves to POLL_RD.
- POLL_RD and POLL_WT loop until the state byte reads 3, then move to RPL_RD.
- RPL_RD and RPL_WT read the 32 reply bytes, then move to CLR_WR.
- CLR_WR writes state 0 and returns to IDLE.

Receive engine states and transitions:
- INIT makes three writes, then moves to SCAN_RD.
- SCAN_RD and SCAN_WT read one channel's state byte. A value of 1 leads to MARK_WR. Any other value moves the scan to the next channel.
- MARK_WR writes state 2, then moves to MSG_RD.
- MSG_RD and MSG_WT read the 32 message bytes, then move to OFFER.
- OFFER holds the message until acknowledged, then moves to RPL_WR.
- RPL_WR writes the 32 reply bytes, then moves to FIN_WR.
- FIN_WR writes state 3 and returns to SCAN_RD for the next channel.

Top module: `mbx_chan_ctrl`

## Requirements
- R1: After reset, the block writes 6 (channel count minus one) to 0x200 and to 0x300, and writes 0xFF to the alive byte at 0x31F.
- R2: A send request whose channel number is above 6 produces a one-cycle `snd_err` pulse in the cycle after acceptance. It leaves the send area and `snd_status` unchanged.
- R3: For a send on channel n, message byte i (bits 8i+7:8i of `snd_msg`) is written to 0x220+32n+i. All 32 bytes are in place before state byte 0x201+n is written with 1.
- R4: After posting, `snd_status` reads 2 (sent, awaiting reply). When state byte 0x201+n becomes 3, the block reads the slot and writes 0 to the state byte. It then pulses `snd_done` with `snd_reply` byte i equal to slot byte i, and `snd_status` reads 3 (complete).
- R5: A send to a channel whose state byte is not 0 is held with `snd_status` = 1 (waiting). The slot and state byte are not written until the state byte reads 0, and then the send proceeds.
- R6: When receive state byte 0x301+n holds 1, the block writes 2 to it. It then raises `rcv_valid` with `rcv_chan` = n and `rcv_msg` byte i equal to byte 0x320+32n+i.
- R7: While `rcv_valid` is high and `rcv_ack` is low, the offer stays unchanged. On `rcv_ack`, `rcv_reply` byte i is written to 0x320+32n+i, and then 3 is written to 0x301+n.
- R8: The patch-control byte at 0x21F is never written.
- R9: `snd_ready` is low from acceptance of a valid send until its completion, and high otherwise.
- R10: Receive state bytes holding 0, 2 or 3 are left unchanged and raise no `rcv_valid`.
- R11: At most one RAM access (read or write) is made per cycle. Read data is taken one cycle after `ram_re`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ram_addr | output | AW (10) | Shared RAM byte address |
| ram_we | output | 1 | RAM write strobe |
| ram_re | output | 1 | RAM read strobe |
| ram_wdata | output | 8 | RAM write byte |
| ram_rdata | input | 8 | RAM read byte, valid the cycle after `ram_re` |
| snd_valid | input | 1 | Send request |
| snd_ready | output | 1 | Send engine can accept a request |
| snd_chan | input | 3 | Send channel number |
| snd_msg | input | 256 | Message to send, byte i in bits 8i+7:8i |
| snd_err | output | 1 | Pulse: channel number out of range |
| snd_status | output | 3 | 0 unused, 1 waiting, 2 sent, 3 complete |
| snd_done | output | 1 | Pulse: reply captured |
| snd_reply | output | 256 | Reply read back from the slot |
| rcv_valid | output | 1 | A received message is offered |
| rcv_chan | output | 3 | Channel of the offered message |
| rcv_msg | output | 256 | Offered message |
| rcv_ack | input | 1 | Offer taken; reply is on `rcv_reply` |
| rcv_reply | input | 256 | Reply to write back |

## Verification
The hardest path to reach from the ports is the held send in R5. The send engine only waits when the coprocessor side has left the channel busy, and the coprocessor side is not part of this block. The bench therefore plays the coprocessor in its RAM model: it presets the state byte to 2 and fills the slot with a marker before issuing the request. While the send is held, it confirms that the marker and the state byte stay untouched, then releases the channel. The ordering in R3 is checked by a snapshot of the slot, taken inside the RAM model at the exact edge where the state byte becomes 1.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    // Per-channel handshake codes kept in the shared RAM.
    typedef enum logic [7:0] {
        CH_IDLE = 8'd0,
        CH_NEW  = 8'd1,
        CH_RCVD = 8'd2,
        CH_DONE = 8'd3
    } chan_state_e;

    // Progress of the message held by the send engine.
    typedef enum logic [2:0] {
        MS_UNUSED   = 3'd0,
        MS_WAITING  = 3'd1,
        MS_SENT     = 3'd2,
        MS_COMPLETE = 3'd3,
        MS_UNSOL    = 3'd6
    } msg_status_e;

    // Offset of slot 0 from the start of a mailbox area.
    localparam int SLOT_OFS = 32;

    // Value written to the alive byte.
    localparam logic [7:0] ALIVE_MARK = 8'hFF;

endpackage

// File: rtl/mbx_port_arb.sv
module mbx_port_arb #(
    parameter int NP = 2,
    parameter int AW = 10
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NP-1:0]          req,
    input  logic [NP-1:0]          we,
    input  logic [NP-1:0][AW-1:0]  addr,
    input  logic [NP-1:0][7:0]     wdata,
    output logic [NP-1:0]          gnt,
    output logic [NP-1:0]          rvalid,
    output logic [AW-1:0]          ram_addr,
    output logic                   ram_we,
    output logic                   ram_re,
    output logic [7:0]             ram_wdata
);
    localparam int PW = (NP > 1) ? $clog2(NP) : 1;

    logic [PW-1:0] last_q;

    // Round robin: search starts one past the last winner.
    always_comb begin
        logic found;
        found = 1'b0;
        gnt   = '0;
        for (int k = 0; k < NP; k++) begin
            if (!found && req[(int'(last_q) + 1 + k) % NP]) begin
                gnt[(int'(last_q) + 1 + k) % NP] = 1'b1;
                found = 1'b1;
            end
        end
    end

    always_comb begin
        ram_addr  = '0;
        ram_we    = 1'b0;
        ram_wdata = '0;
        for (int i = 0; i < NP; i++) begin
            if (gnt[i]) begin
                ram_addr  = addr[i];
                ram_we    = we[i];
                ram_wdata = wdata[i];
            end
        end
    end

    assign ram_re = |(gnt & ~we);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= '0;
            rvalid <= '0;
        end else begin
            rvalid <= gnt & ~we;
            for (int i = 0; i < NP; i++) begin
                if (gnt[i]) last_q <= PW'(i);
            end
        end
    end

    // R11: a single winner per cycle
    a_r11_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    // R11: read data is only handed back after a RAM read
    a_r11_rvalid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (|rvalid) |-> $past(ram_re));

endmodule

// File: rtl/mbx_send_eng.sv
module mbx_send_eng
    import mbx_pkg::*;
#(
    parameter int AW        = 10,
    parameter int NCHAN     = 7,
    parameter int MSG_BYTES = 32,
    parameter int BASE      = 'h200,
    parameter int CW        = 3,
    parameter int MW        = 256
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [CW-1:0] req_chan,
    input  logic [MW-1:0] req_msg,
    output logic          err,
    output logic [2:0]    status,
    output logic          done,
    output logic [MW-1:0] reply,
    output logic          m_req,
    output logic          m_we,
    output logic [AW-1:0] m_addr,
    output logic [7:0]    m_wdata,
    input  logic          m_gnt,
    input  logic          m_rvalid,
    input  logic [7:0]    m_rdata
);
    localparam int            IW   = $clog2(MSG_BYTES);
    localparam logic [IW-1:0] LAST = IW'(MSG_BYTES - 1);

    typedef enum logic [3:0] {
        SX_IDLE, SX_CHK_RD, SX_CHK_WT, SX_MSG_WR, SX_NEW_WR,
        SX_POLL_RD, SX_POLL_WT, SX_RPL_RD, SX_RPL_WT, SX_CLR_WR
    } sx_e;

    sx_e           st_q, st_d;
    logic [CW-1:0] chan_q;
    logic [MW-1:0] msg_q, rpl_q;
    logic [IW-1:0] idx_q;
    logic [IW:0]   wcnt_q;
    msg_status_e   stat_q;
    logic          err_q, done_q;
    logic          accept, bad_chan;
    logic [AW-1:0] st_addr, slot_addr;

    assign req_ready = (st_q == SX_IDLE);
    assign accept    = req_valid && req_ready;
    assign bad_chan  = req_chan > CW'(NCHAN - 1);
    assign st_addr   = AW'(BASE + 1) + AW'(chan_q);
    assign slot_addr = AW'(BASE + SLOT_OFS) + AW'(chan_q) * AW'(MSG_BYTES) + AW'(idx_q);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= SX_IDLE;
        else        st_q <= st_d;
    end

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SX_IDLE:    if (accept && !bad_chan) st_d = SX_CHK_RD;
            SX_CHK_RD:  if (m_gnt) st_d = SX_CHK_WT;
            SX_CHK_WT:  if (m_rvalid) st_d = (m_rdata == CH_IDLE) ? SX_MSG_WR : SX_CHK_RD;
            SX_MSG_WR:  if (m_gnt && idx_q == LAST) st_d = SX_NEW_WR;
            SX_NEW_WR:  if (m_gnt) st_d = SX_POLL_RD;
            SX_POLL_RD: if (m_gnt) st_d = SX_POLL_WT;
            SX_POLL_WT: if (m_rvalid) st_d = (m_rdata == CH_DONE) ? SX_RPL_RD : SX_POLL_RD;
            SX_RPL_RD:  if (m_gnt) st_d = SX_RPL_WT;
            SX_RPL_WT:  if (m_rvalid) st_d = (idx_q == LAST) ? SX_CLR_WR : SX_RPL_RD;
            SX_CLR_WR:  if (m_gnt) st_d = SX_IDLE;
            default:    st_d = SX_IDLE;
        endcase
    end

    // RAM port outputs
    always_comb begin
        m_req   = 1'b0;
        m_we    = 1'b0;
        m_addr  = st_addr;
        m_wdata = '0;
        unique case (st_q)
            SX_CHK_RD, SX_POLL_RD: m_req = 1'b1;
            SX_MSG_WR: begin
                m_req   = 1'b1;
                m_we    = 1'b1;
                m_addr  = slot_addr;
                m_wdata = msg_q[idx_q*8 +: 8];
            end
            SX_NEW_WR: begin
                m_req   = 1'b1;
                m_we    = 1'b1;
                m_wdata = CH_NEW;
            end
            SX_RPL_RD: begin
                m_req  = 1'b1;
                m_addr = slot_addr;
            end
            SX_CLR_WR: begin
                m_req   = 1'b1;
                m_we    = 1'b1;
                m_wdata = CH_IDLE;
            end
            default: ;
        endcase
    end

    // Data path
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_q <= '0;
            msg_q  <= '0;
            rpl_q  <= '0;
            idx_q  <= '0;
            wcnt_q <= '0;
            stat_q <= MS_UNUSED;
            err_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            err_q  <= 1'b0;
            done_q <= 1'b0;
            unique case (st_q)
                SX_IDLE: if (accept) begin
                    if (bad_chan) begin
                        err_q <= 1'b1;
                    end else begin
                        chan_q <= req_chan;
                        msg_q  <= req_msg;
                        idx_q  <= '0;
                        wcnt_q <= '0;
                        stat_q <= MS_WAITING;
                    end
                end
                SX_MSG_WR: if (m_gnt) begin
                    idx_q  <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
                    wcnt_q <= wcnt_q + 1'b1;
                end
                SX_NEW_WR: if (m_gnt) stat_q <= MS_SENT;
                SX_RPL_WT: if (m_rvalid) begin
                    rpl_q[idx_q*8 +: 8] <= m_rdata;
                    idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
                end
                SX_CLR_WR: if (m_gnt) begin
                    done_q <= 1'b1;
                    stat_q <= MS_COMPLETE;
                end
                default: ;
            endcase
        end
    end

    assign err    = err_q;
    assign done   = done_q;
    assign status = stat_q;
    assign reply  = rpl_q;

    // R2: an error pulse only follows an out-of-range request
    a_r2_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> $past(req_valid && req_chan > CW'(NCHAN - 1)));

    // R3: the whole body is written before the new flag
    a_r3_body_before_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SX_NEW_WR && m_gnt) |-> (wcnt_q == (IW+1)'(MSG_BYTES)));

    // R4: completion follows the clear of the state byte
    a_r4_done_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> $past(st_q == SX_CLR_WR && m_gnt));

    // R9: ready only when no message is in flight
    a_r9_ready_status: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (stat_q == MS_UNUSED || stat_q == MS_COMPLETE));

endmodule

// File: rtl/mbx_recv_eng.sv
module mbx_recv_eng
    import mbx_pkg::*;
#(
    parameter int AW        = 10,
    parameter int NCHAN     = 7,
    parameter int MSG_BYTES = 32,
    parameter int SND_BASE  = 'h200,
    parameter int RCV_BASE  = 'h300,
    parameter int ALIVE_OFS = 'h1F,
    parameter int CW        = 3,
    parameter int MW        = 256
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic          offer_valid,
    output logic [CW-1:0] offer_chan,
    output logic [MW-1:0] offer_msg,
    input  logic          offer_ack,
    input  logic [MW-1:0] offer_reply,
    output logic          m_req,
    output logic          m_we,
    output logic [AW-1:0] m_addr,
    output logic [7:0]    m_wdata,
    input  logic          m_gnt,
    input  logic          m_rvalid,
    input  logic [7:0]    m_rdata
);
    localparam int            IW    = $clog2(MSG_BYTES);
    localparam logic [IW-1:0] LAST  = IW'(MSG_BYTES - 1);
    localparam logic [CW-1:0] CLAST = CW'(NCHAN - 1);

    typedef enum logic [3:0] {
        RX_INIT, RX_SCAN_RD, RX_SCAN_WT, RX_MARK_WR, RX_MSG_RD,
        RX_MSG_WT, RX_OFFER, RX_RPL_WR, RX_FIN_WR
    } rx_e;

    rx_e           st_q, st_d;
    logic [1:0]    ini_q;
    logic [CW-1:0] chan_q;
    logic [IW-1:0] idx_q;
    logic [MW-1:0] buf_q;
    logic [AW-1:0] st_addr, slot_addr, ini_addr;
    logic [CW-1:0] chan_nx;

    assign st_addr   = AW'(RCV_BASE + 1) + AW'(chan_q);
    assign slot_addr = AW'(RCV_BASE + SLOT_OFS) + AW'(chan_q) * AW'(MSG_BYTES) + AW'(idx_q);
    assign chan_nx   = (chan_q == CLAST) ? '0 : chan_q + 1'b1;

    always_comb begin
        unique case (ini_q)
            2'd0:    ini_addr = AW'(SND_BASE);
            2'd1:    ini_addr = AW'(RCV_BASE);
            default: ini_addr = AW'(RCV_BASE + ALIVE_OFS);
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RX_INIT;
        else        st_q <= st_d;
    end

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RX_INIT:    if (m_gnt && ini_q == 2'd2) st_d = RX_SCAN_RD;
            RX_SCAN_RD: if (m_gnt) st_d = RX_SCAN_WT;
            RX_SCAN_WT: if (m_rvalid) st_d = (m_rdata == CH_NEW) ? RX_MARK_WR : RX_SCAN_RD;
            RX_MARK_WR: if (m_gnt) st_d = RX_MSG_RD;
            RX_MSG_RD:  if (m_gnt) st_d = RX_MSG_WT;
            RX_MSG_WT:  if (m_rvalid) st_d = (idx_q == LAST) ? RX_OFFER : RX_MSG_RD;
            RX_OFFER:   if (offer_ack) st_d = RX_RPL_WR;
            RX_RPL_WR:  if (m_gnt && idx_q == LAST) st_d = RX_FIN_WR;
            RX_FIN_WR:  if (m_gnt) st_d = RX_SCAN_RD;
            default:    st_d = RX_INIT;
        endcase
    end

    // RAM port and offer outputs
    always_comb begin
        m_req       = 1'b0;
        m_we        = 1'b0;
        m_addr      = st_addr;
        m_wdata     = '0;
        offer_valid = (st_q == RX_OFFER);
        unique case (st_q)
            RX_INIT: begin
                m_req   = 1'b1;
                m_we    = 1'b1;
                m_addr  = ini_addr;
                m_wdata = (ini_q == 2'd2) ? ALIVE_MARK : 8'(NCHAN - 1);
            end
            RX_SCAN_RD: m_req = 1'b1;
            RX_MARK_WR: begin
                m_req   = 1'b1;
                m_we    = 1'b1;
                m_wdata = CH_RCVD;
            end
            RX_MSG_RD: begin
                m_req  = 1'b1;
                m_addr = slot_addr;
            end
            RX_RPL_WR: begin
                m_req   = 1'b1;
                m_we    = 1'b1;
                m_addr  = slot_addr;
                m_wdata = buf_q[idx_q*8 +: 8];
            end
            RX_FIN_WR: begin
                m_req   = 1'b1;
                m_we    = 1'b1;
                m_wdata = CH_DONE;
            end
            default: ;
        endcase
    end

    // Data path
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ini_q  <= '0;
            chan_q <= '0;
            idx_q  <= '0;
            buf_q  <= '0;
        end else begin
            unique case (st_q)
                RX_INIT:    if (m_gnt) ini_q <= ini_q + 1'b1;
                RX_SCAN_WT: if (m_rvalid && m_rdata != CH_NEW) chan_q <= chan_nx;
                RX_MARK_WR: if (m_gnt) idx_q <= '0;
                RX_MSG_WT:  if (m_rvalid) begin
                    buf_q[idx_q*8 +: 8] <= m_rdata;
                    idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
                end
                RX_OFFER:   if (offer_ack) buf_q <= offer_reply;
                RX_RPL_WR:  if (m_gnt) idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
                RX_FIN_WR:  if (m_gnt) chan_q <= chan_nx;
                default: ;
            endcase
        end
    end

    assign offer_chan = chan_q;
    assign offer_msg  = buf_q;

    // R7: an offer holds still until it is acknowledged
    a_r7_offer_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (offer_valid && !offer_ack) |=> (offer_valid && $stable(offer_msg) && $stable(offer_chan)));

    // R6: an offer is only made after the state byte was marked received
    a_r6_offer_after_mark: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(offer_valid) |-> $past(st_q == RX_MSG_WT));

endmodule

// File: rtl/mbx_chan_ctrl.sv
module mbx_chan_ctrl #(
    parameter int AW        = 10,
    parameter int NCHAN     = 7,
    parameter int MSG_BYTES = 32,
    parameter int SND_BASE  = 'h200,
    parameter int RCV_BASE  = 'h300,
    parameter int ALIVE_OFS = 'h1F,
    localparam int CW       = $clog2(NCHAN + 1),
    localparam int MW       = MSG_BYTES * 8
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [AW-1:0] ram_addr,
    output logic          ram_we,
    output logic          ram_re,
    output logic [7:0]    ram_wdata,
    input  logic [7:0]    ram_rdata,
    input  logic          snd_valid,
    output logic          snd_ready,
    input  logic [CW-1:0] snd_chan,
    input  logic [MW-1:0] snd_msg,
    output logic          snd_err,
    output logic [2:0]    snd_status,
    output logic          snd_done,
    output logic [MW-1:0] snd_reply,
    output logic          rcv_valid,
    output logic [CW-1:0] rcv_chan,
    output logic [MW-1:0] rcv_msg,
    input  logic          rcv_ack,
    input  logic [MW-1:0] rcv_reply
);
    localparam int NP = 2;

    logic [NP-1:0]         a_req, a_we, a_gnt, a_rv;
    logic [NP-1:0][AW-1:0] a_addr;
    logic [NP-1:0][7:0]    a_wd;

    // Port 0: receive engine, port 1: send engine
    mbx_recv_eng #(
        .AW(AW), .NCHAN(NCHAN), .MSG_BYTES(MSG_BYTES), .SND_BASE(SND_BASE),
        .RCV_BASE(RCV_BASE), .ALIVE_OFS(ALIVE_OFS), .CW(CW), .MW(MW)
    ) u_recv (
        .clk(clk), .rst_n(rst_n),
        .offer_valid(rcv_valid), .offer_chan(rcv_chan), .offer_msg(rcv_msg),
        .offer_ack(rcv_ack), .offer_reply(rcv_reply),
        .m_req(a_req[0]), .m_we(a_we[0]), .m_addr(a_addr[0]), .m_wdata(a_wd[0]),
        .m_gnt(a_gnt[0]), .m_rvalid(a_rv[0]), .m_rdata(ram_rdata)
    );

    mbx_send_eng #(
        .AW(AW), .NCHAN(NCHAN), .MSG_BYTES(MSG_BYTES), .BASE(SND_BASE),
        .CW(CW), .MW(MW)
    ) u_send (
        .clk(clk), .rst_n(rst_n),
        .req_valid(snd_valid), .req_ready(snd_ready), .req_chan(snd_chan),
        .req_msg(snd_msg), .err(snd_err), .status(snd_status),
        .done(snd_done), .reply(snd_reply),
        .m_req(a_req[1]), .m_we(a_we[1]), .m_addr(a_addr[1]), .m_wdata(a_wd[1]),
        .m_gnt(a_gnt[1]), .m_rvalid(a_rv[1]), .m_rdata(ram_rdata)
    );

    mbx_port_arb #(.NP(NP), .AW(AW)) u_arb (
        .clk(clk), .rst_n(rst_n),
        .req(a_req), .we(a_we), .addr(a_addr), .wdata(a_wd),
        .gnt(a_gnt), .rvalid(a_rv),
        .ram_addr(ram_addr), .ram_we(ram_we), .ram_re(ram_re), .ram_wdata(ram_wdata)
    );

    // R8: the patch-control byte is never written
    a_r8_patch_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (ram_addr != AW'(SND_BASE + ALIVE_OFS)));

    // R11: never a read and a write together
    a_r11_one_access: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_we && ram_re));

endmodule

// File: tb/test_mbx_chan_ctrl.sv
`timescale 1ns/1ps
module test_mbx_chan_ctrl;
    localparam int NCH = 7;
    localparam int MB  = 32;
    localparam int MW  = 256;
    localparam int AW  = 10;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n;
    logic [AW-1:0] ram_addr;
    logic          ram_we, ram_re;
    logic [7:0]    ram_wdata;
    logic [7:0]    ram_rdata;
    logic          snd_valid, snd_ready, snd_err, snd_done;
    logic [2:0]    snd_chan, snd_status;
    logic [MW-1:0] snd_msg, snd_reply;
    logic          rcv_valid, rcv_ack;
    logic [2:0]    rcv_chan;
    logic [MW-1:0] rcv_msg, rcv_reply;

    mbx_chan_ctrl i_mbx_chan_ctrl (
        .clk(clk), .rst_n(rst_n),
        .ram_addr(ram_addr), .ram_we(ram_we), .ram_re(ram_re),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
        .snd_valid(snd_valid), .snd_ready(snd_ready), .snd_chan(snd_chan),
        .snd_msg(snd_msg), .snd_err(snd_err), .snd_status(snd_status),
        .snd_done(snd_done), .snd_reply(snd_reply),
        .rcv_valid(rcv_valid), .rcv_chan(rcv_chan), .rcv_msg(rcv_msg),
        .rcv_ack(rcv_ack), .rcv_reply(rcv_reply)
    );

    int errs = 0;
    int checks = 0;
    bit finished = 0;

    logic [7:0]    mem [0:1023];
    logic [MW-1:0] snap [0:NCH-1];
    int            patch_hits = 0;
    int            dual_hits  = 0;

    // Shared RAM model with one-cycle read latency
    always @(posedge clk) begin
        if (ram_we && ram_re) dual_hits++;
        if (ram_we) begin
            if (ram_addr == 10'h21F) patch_hits++;
            if (ram_addr >= 10'h201 && ram_addr <= 10'h207 && ram_wdata == 8'd1)
                for (int b = 0; b < MB; b++)
                    snap[int'(ram_addr) - 'h201][b*8 +: 8] <= mem['h220 + (int'(ram_addr) - 'h201)*MB + b];
            mem[ram_addr] <= ram_wdata;
        end
        if (ram_re) ram_rdata <= mem[ram_addr];
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [MW-1:0] act, input logic [MW-1:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [MW-1:0] pat(input int seed, input int mul);
        logic [MW-1:0] v;
        for (int b = 0; b < MB; b++) v[b*8 +: 8] = 8'((seed + b*mul) & 255);
        return v;
    endfunction

    function automatic logic [MW-1:0] slot(input int base);
        logic [MW-1:0] v;
        for (int b = 0; b < MB; b++) v[b*8 +: 8] = mem[base + b];
        return v;
    endfunction

    task automatic fill(input int base, input logic [MW-1:0] v);
        for (int b = 0; b < MB; b++) mem[base + b] = v[b*8 +: 8];
    endtask

    function automatic int area_sum(input int lo, input int hi);
        int s = 0;
        for (int a = lo; a <= hi; a++) s += int'(mem[a]);
        return s;
    endfunction

    task automatic wait_mem(input int a, input logic [7:0] v, output bit ok);
        ok = 0;
        for (int i = 0; i < 4000 && !ok; i++) begin
            @(negedge clk);
            if (mem[a] == v) ok = 1;
        end
    endtask

    task automatic issue_send(input int c, input logic [MW-1:0] m);
        while (!snd_ready) @(negedge clk);
        snd_valid = 1'b1;
        snd_chan  = 3'(c);
        snd_msg   = m;
        @(negedge clk);
        snd_valid = 1'b0;
    endtask

    task automatic run_send(input int c, input bit held);
        logic [MW-1:0] m, r;
        bit ok;
        m = pat(c*37 + 5, 11);
        r = pat(c*53 + 128, 7);
        if (held) begin
            mem['h201 + c] = 8'd2;
            fill('h220 + c*MB, {MB{8'hEE}});
        end
        issue_send(c, m);
        chk(snd_ready == 1'b0, "R9", "ready low while busy", MW'(snd_ready), 0);
        if (held) begin
            repeat (300) @(negedge clk);
            chk(snd_status == 3'd1, "R5", "status waiting", MW'(snd_status), 1);
            chk(mem['h201 + c] == 8'd2, "R5", "busy state untouched", MW'(mem['h201 + c]), 2);
            chk(slot('h220 + c*MB) == {MB{8'hEE}}, "R5", "slot untouched", slot('h220 + c*MB), {MB{8'hEE}});
            mem['h201 + c] = 8'd0;
        end
        wait_mem('h201 + c, 8'd1, ok);
        chk(ok, "R3", "state byte posted", MW'(mem['h201 + c]), 1);
        chk(snap[c] == m, "R3", "slot complete at post", snap[c], m);
        chk(snd_status == 3'd2, "R4", "status sent", MW'(snd_status), 2);
        fill('h220 + c*MB, r);
        mem['h201 + c] = 8'd3;
        ok = 0;
        for (int i = 0; i < 4000 && !ok; i++) begin
            @(negedge clk);
            if (snd_done) ok = 1;
        end
        chk(ok, "R4", "done pulse", MW'(snd_done), 1);
        chk(snd_reply == r, "R4", "reply bytes", snd_reply, r);
        chk(snd_status == 3'd3, "R4", "status complete", MW'(snd_status), 3);
        chk(mem['h201 + c] == 8'd0, "R4", "state back to idle", MW'(mem['h201 + c]), 0);
        chk(snd_ready == 1'b1, "R9", "ready after done", MW'(snd_ready), 1);
    endtask

    task automatic run_recv(input int c);
        logic [MW-1:0] m, r;
        bit ok;
        m = pat(c*29 + 64, 3);
        r = ~m;
        fill('h320 + c*MB, m);
        mem['h301 + c] = 8'd1;
        ok = 0;
        for (int i = 0; i < 4000 && !ok; i++) begin
            @(negedge clk);
            if (rcv_valid) ok = 1;
        end
        chk(ok, "R6", "offer raised", MW'(rcv_valid), 1);
        chk(int'(rcv_chan) == c, "R6", "offer channel", MW'(rcv_chan), MW'(c));
        chk(rcv_msg == m, "R6", "offer bytes", rcv_msg, m);
        chk(mem['h301 + c] == 8'd2, "R6", "marked received", MW'(mem['h301 + c]), 2);
        repeat (3) @(negedge clk);
        chk(rcv_valid && rcv_msg == m, "R7", "offer held", rcv_msg, m);
        rcv_reply = r;
        rcv_ack   = 1'b1;
        @(negedge clk);
        rcv_ack = 1'b0;
        chk(rcv_valid == 1'b0, "R7", "offer dropped after ack", MW'(rcv_valid), 0);
        wait_mem('h301 + c, 8'd3, ok);
        chk(ok, "R7", "marked complete", MW'(mem['h301 + c]), 3);
        chk(slot('h320 + c*MB) == r, "R7", "reply in slot", slot('h320 + c*MB), r);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        int s0;
        bit seen;
        for (int a = 0; a < 1024; a++) mem[a] = 8'd0;
        mem['h21F] = 8'h5A;
        rst_n = 1'b0;
        snd_valid = 1'b0; snd_chan = '0; snd_msg = '0;
        rcv_ack = 1'b0; rcv_reply = '0;
        repeat (4) @(negedge clk);
        chk(snd_status == 3'd0 && !snd_done && !snd_err, "R4", "reset status", MW'(snd_status), 0);
        chk(rcv_valid == 1'b0, "R6", "reset offer", MW'(rcv_valid), 0);
        chk(snd_ready == 1'b1, "R9", "reset ready", MW'(snd_ready), 1);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        chk(mem['h200] == 8'd6, "R1", "send max channel", MW'(mem['h200]), 6);
        chk(mem['h300] == 8'd6, "R1", "recv max channel", MW'(mem['h300]), 6);
        chk(mem['h31F] == 8'hFF, "R1", "alive byte", MW'(mem['h31F]), 'hFF);

        // R2: out-of-range channel
        s0 = area_sum('h201, 'h2FF);
        issue_send(7, pat(1, 1));
        chk(snd_err == 1'b1, "R2", "error pulse", MW'(snd_err), 1);
        @(negedge clk);
        chk(snd_err == 1'b0, "R2", "error one cycle", MW'(snd_err), 0);
        repeat (100) @(negedge clk);
        chk(area_sum('h201, 'h2FF) == s0, "R2", "send area unchanged", MW'(area_sum('h201, 'h2FF)), MW'(s0));
        chk(snd_status == 3'd0, "R2", "status unchanged", MW'(snd_status), 0);

        // R3 R4: every channel
        for (int c = 0; c < NCH; c++) run_send(c, 1'b0);
        // R5: held send
        run_send(2, 1'b1);

        // R6 R7: every receive channel
        for (int c = 0; c < NCH; c++) run_recv(c);

        // R10: non-new states are ignored
        for (int c = 0; c < NCH; c++) mem['h301 + c] = 8'(c % 4 == 1 ? 0 : c % 4);
        seen = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (rcv_valid) seen = 1;
        end
        chk(!seen, "R10", "no offer", MW'(seen), 0);
        for (int c = 0; c < NCH; c++)
            chk(mem['h301 + c] == 8'(c % 4 == 1 ? 0 : c % 4), "R10", "state unchanged",
                MW'(mem['h301 + c]), MW'(c % 4 == 1 ? 0 : c % 4));

        chk(patch_hits == 0 && mem['h21F] == 8'h5A, "R8", "patch byte", MW'(mem['h21F]), 'h5A);
        chk(dual_hits == 0, "R11", "single access per cycle", MW'(dual_hits), 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule